// File: doc/BRIEF.md
# Modem Status Register with Loopback

This block keeps the modem-side status of a serial port. It samples four modem input levels (carrier detect, ring indicator, data set ready, clear to send) whenever an update strobe arrives. It keeps those levels in the upper half of an 8-bit status byte. The lower half holds sticky change indicators that record which lines moved since the status was last consumed. Every update also raises a changed flag. The interrupt logic watches this flag and clears it when it reads its identification value.

Software reads the byte through a read strobe. The read data output always shows the value that a read would return. The clock edge on which the strobe is high consumes that value and clears the change indicators.

A loopback test mode is taken from bit 4 of the modem control value. In that mode the read data is not taken from the stored inputs. It is rebuilt from the modem control outputs, so a driver can test its own control lines. In this mode reads leave the stored state alone.

Top module: `modem_status_reg`

## Requirements
- R1: Bits 7, 6, 5 and 4 of the status byte hold the last sampled carrier detect, ring indicator, data set ready and clear to send levels. They come from line_in[3], line_in[2], line_in[1] and line_in[0] respectively, taken on a clock edge with line_upd high.
- R2: After reset, rd_data reads 0xB0 (carrier, data set ready and clear to send asserted, ring not asserted, no change bits) and chg_flag is 0.
- R3: On an update, status bit 3 is set if carrier detect differs from its stored level. Bit 1 is set if data set ready differs, and bit 0 if clear to send differs.
- R4: On an update, status bit 2 is set only when the ring indicator goes from 1 to 0. A rise of the ring indicator sets no change bit.
- R5: Every update sets chg_flag, even one that changes no level. chg_flag stays set until a cycle with chg_clr high and no update. An update in the same cycle as chg_clr leaves it set.
- R6: Outside loopback (mctl[4]=0), rd_data shows the stored byte. A clock edge with rd_stb high clears bits 3..0 and keeps bits 7..4.
- R7: With mctl[4]=1, rd_data is built from the control bits: mctl[3] to bit 7, mctl[2] to bit 6, mctl[0] to bit 5, mctl[1] to bit 4, and bits 3..0 read 0. With mctl[4]=0, the other control bits have no effect on rd_data.
- R8: A read in loopback clears nothing. After loopback is left, the stored byte reads back unchanged.
- R9: Change bits accumulate over several updates until a normal read clears them.
- R10: When an update and a normal read share a clock edge, the change bits produced by that update survive. Only the older bits are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_upd | input | 1 | Sample line_in this cycle |
| line_in | input | 4 | Modem inputs: [3] carrier, [2] ring, [1] data set ready, [0] clear to send |
| mctl | input | 5 | Modem control value; bit 4 selects loopback |
| rd_stb | input | 1 | Consume the status byte this cycle |
| rd_data | output | 8 | Status byte as a read would return it |
| chg_flag | output | 1 | An update occurred since the last clear |
| chg_clr | input | 1 | Clear chg_flag (interrupt identification read) |

## Verification
The bench checks the ring indicator in both directions. A design that used plain inequality for bit 2 would flag the rise as well as the fall. It checks several updates before a read, which exposes a design that overwrites the change bits instead of ORing them. It checks a read and an update on the same edge, where a clear that wins would lose the new change. It checks reads made in loopback and then leaves loopback, so a design that clears on every read, or that swaps the mctl[0] and mctl[1] positions, returns a wrong byte. It also puts chg_clr and an update in the same cycle, where a clear-first design drops the flag.

// File: rtl/modem_status_reg.sv
module modem_status_reg #(
  parameter logic [7:0] RESET_STATUS = 8'hB0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_upd,
  input  logic [3:0] line_in,
  input  logic [4:0] mctl,
  input  logic       rd_stb,
  output logic [7:0] rd_data,
  output logic       chg_flag,
  input  logic       chg_clr
);

  logic [3:0] lvl_q;
  logic [3:0] dlt_q;
  logic [3:0] dlt_new;
  logic       loop;

  assign loop = mctl[4];

  assign dlt_new = line_upd ? {lvl_q[3] ^ line_in[3],
                               lvl_q[2] & ~line_in[2],
                               lvl_q[1] ^ line_in[1],
                               lvl_q[0] ^ line_in[0]} : 4'b0000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q    <= RESET_STATUS[7:4];
      dlt_q    <= RESET_STATUS[3:0];
      chg_flag <= 1'b0;
    end else begin
      if (line_upd) lvl_q <= line_in;
      dlt_q    <= ((rd_stb && !loop) ? 4'b0000 : dlt_q) | dlt_new;
      chg_flag <= line_upd | (chg_flag & ~chg_clr);
    end
  end

  assign rd_data = loop ? {mctl[3], mctl[2], mctl[0], mctl[1], 4'b0000}
                        : {lvl_q, dlt_q};

  // R1: sampled levels appear in the upper nibble
  p_levels_track_r1: assert property (@(posedge clk) disable iff (!rst_n)
    line_upd |=> lvl_q == $past(line_in));

  // R5: an update always raises the flag
  p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    line_upd |=> chg_flag);

  // R5: flag holds without a clear
  p_flag_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_flag && !chg_clr) |=> chg_flag);

  // R6: a normal read with no update leaves no change bits
  p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !loop && !line_upd) |=> dlt_q == 4'b0000);

  // R8: a loopback read without an update disturbs nothing
  p_loop_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && loop && !line_upd) |=> ($stable(dlt_q) && $stable(lvl_q)));

  // R9: with neither read nor update the stored byte is stable
  p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && !line_upd) |=> ($stable(dlt_q) && $stable(lvl_q)));

endmodule

// File: tb/modem_status_reg_tb.sv
module modem_status_reg_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_upd = 1'b0;
  logic [3:0] line_in = 4'h0;
  logic [4:0] mctl = 5'h0;
  logic       rd_stb = 1'b0;
  logic       chg_clr = 1'b0;
  logic [7:0] rd_data;
  logic       chg_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [8:0] exp_q[$];
  string      tag_q[$];

  logic [3:0] m_hi = 4'hB;
  logic [3:0] m_lo = 4'h0;
  logic       m_flag = 1'b0;

  always #2.5 clk = ~clk;

  modem_status_reg u_dut (
    .clk(clk), .rst_n(rst_n), .line_upd(line_upd), .line_in(line_in),
    .mctl(mctl), .rd_stb(rd_stb), .rd_data(rd_data), .chg_flag(chg_flag),
    .chg_clr(chg_clr)
  );

  task automatic step(input logic u, input logic [3:0] ln, input logic r,
                      input logic c, input logic [4:0] ct, input string tag);
    logic [3:0] d;
    logic [7:0] e;
    @(negedge clk);
    line_upd = u; line_in = ln; rd_stb = r; chg_clr = c; mctl = ct;
    d = 4'h0;
    if (u) begin
      d[3] = m_hi[3] != ln[3];
      d[2] = m_hi[2] && !ln[2];
      d[1] = m_hi[1] != ln[1];
      d[0] = m_hi[0] != ln[0];
    end
    m_lo = ((r && !ct[4]) ? 4'h0 : m_lo) | d;
    if (u) m_hi = ln;
    m_flag = u ? 1'b1 : (c ? 1'b0 : m_flag);
    e = ct[4] ? {ct[3], ct[2], ct[0], ct[1], 4'h0} : {m_hi, m_lo};
    exp_q.push_back({m_flag, e});
    tag_q.push_back(tag);
  endtask

  always begin
    @(posedge clk);
    #1;
    if (exp_q.size() > 0) begin
      logic [8:0] ex;
      string t;
      ex = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({chg_flag, rd_data} !== ex) begin
        errors++;
        $display("FAIL %s: got flag=%0b data=%02h expected flag=%0b data=%02h",
                 t, chg_flag, rd_data, ex[8], ex[7:0]);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(0, 4'h0, 0, 0, 5'h00, "R2 reset value");
    step(1, 4'hB, 0, 0, 5'h00, "R5 update without change");
    step(0, 4'hB, 0, 1, 5'h00, "R5 clear");
    step(1, 4'h3, 0, 0, 5'h00, "R3 carrier change");
    step(1, 4'h0, 0, 0, 5'h00, "R9 R3 accumulate dsr cts");
    step(1, 4'h4, 0, 0, 5'h00, "R4 ring rise");
    step(1, 4'h9, 0, 0, 5'h00, "R4 ring fall R1 levels");
    step(0, 4'h9, 1, 0, 5'h00, "R6 read clears low");
    step(0, 4'h9, 0, 0, 5'h16, "R7 loopback map a");
    step(1, 4'h0, 0, 0, 5'h19, "R7 loopback map b");
    step(0, 4'h0, 1, 0, 5'h19, "R8 loopback read");
    step(0, 4'h0, 0, 0, 5'h00, "R8 state kept");
    step(1, 4'h2, 1, 1, 5'h00, "R10 update with read, R5 set wins");
    step(0, 4'h2, 1, 0, 5'h00, "R6 read again");
    step(0, 4'h2, 0, 1, 5'h00, "R5 clear again");
    step(0, 4'h2, 0, 0, 5'h0F, "R7 no remap outside loopback");
    @(negedge clk);
    line_upd = 0; rd_stb = 0; chg_clr = 0; mctl = 0;
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      #100us;
    join_any
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule